// File: doc/BRIEF.md
# Criticality-Aware Functional Unit Steering

This block sits between the issue stage and a set of functional units. Each instruction arrives on a valid/ready handshake with an opcode and two operands. A small programmable table gives every opcode one class bit: timing-critical or non-critical. Critical instructions go only to a reserved pool of units. Non-critical instructions go round-robin to the remaining units. The units are fixed-latency busy stubs with no arithmetic.

A critical unit that holds no instruction drops into a low-wear idle state. Two forms are selectable. In the power-gate form the unit switches off, and waking it costs a programmable latency while the incoming instruction stalls. In the vector form the unit stays powered and its operand inputs are held at a programmable constant.

A baseline mode ignores the class bit and spreads instructions evenly over every unit, with no idle control, so that wear can be compared. Each unit has a counter of the cycles it has spent in a low-wear idle state.

Top module: `fu_steer`

## Requirements
- R1: The class table holds one bit for each of the 64 values of the 6-bit opcode (1 = critical, 0 = non-critical) and is all zero after reset. A write on `tbl_we` to `tbl_addr` with `tbl_bit` takes effect from the next cycle.
- R2: Outside baseline mode, a critical instruction issues only to units 0..N_CRIT-1, and a non-critical one only to units N_CRIT..N-1.
- R3: In every cycle with `in_valid` and `in_ready` high, exactly one bit of `fu_issue` is high. No bit is high in any other cycle.
- R4: Non-critical instructions take the first free unit of their pool at or after the one following the unit last chosen this way, wrapping around.
- R5: An issued unit shows `fu_busy` for LAT cycles and cannot take work during them. `in_ready` is low while no eligible unit is free.
- R6: In power-gate idle form (`cfg_idle_mode`=0), a critical unit that is neither busy nor being issued shows `fu_gate` high from the next cycle. Non-critical units never gate.
- R7: A critical instruction that finds its unit gated sees `in_ready` low for exactly `cfg_wake`+2 cycles: one detection cycle plus a wake-up of `cfg_wake`+1 cycles. It is then issued to that unit.
- R8: In vector idle form (`cfg_idle_mode`=1), critical units never gate. While idle, their `fu_opa` and `fu_opb` equal `cfg_idle_vec`. In the issue cycle they carry the incoming operands, and while busy they carry the latched operands.
- R9: In baseline mode (`cfg_base`=1), the class is ignored, instructions go round-robin over all units starting from unit 0 after reset, no unit gates, and operands are never forced.
- R10: A unit's `idle_cnt` field is zero after reset and adds one in each cycle the unit is gated or vector-held, saturating at its maximum.
- R11: During reset, no unit is busy, no unit gates, no issue occurs and all idle counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 1 | 1 = class-blind baseline spreading |
| cfg_idle_mode | input | 1 | 0 = power gate, 1 = fixed operand vector |
| cfg_wake | input | 3 | Wake latency minus one |
| cfg_idle_vec | input | OPR_W | Operand value held on an idle critical unit |
| tbl_we | input | 1 | Class table write enable |
| tbl_addr | input | OPC_W | Class table write opcode |
| tbl_bit | input | 1 | Class bit to write |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_opc | input | OPC_W | Instruction opcode |
| in_opa | input | OPR_W | First operand |
| in_opb | input | OPR_W | Second operand |
| fu_issue | output | N | Per-unit issue strobe |
| fu_busy | output | N | Per-unit busy feedback |
| fu_gate | output | N | Per-unit power-gate control |
| fu_opc | output | N*OPC_W | Per-unit opcode input |
| fu_opa | output | N*OPR_W | Per-unit first operand input |
| fu_opb | output | N*OPR_W | Per-unit second operand input |
| idle_cnt | output | N*CNT_W | Per-unit low-wear idle cycle count |

## Verification
The assertions assume three things about the inputs. An instruction holds `in_valid`, opcode and operands until it is accepted. The mode inputs change only while no instruction is pending. The class table is not rewritten for an opcode that is waiting. The stimulus follows this by using one task that keeps the request stable until `in_ready`. Mode changes and table writes happen only in idle gaps, and the switch to baseline mode goes through a reset, so the round-robin start point is known. Expected unit choices, stall lengths and counter deltas are worked out from the requirements alone.

// File: rtl/fu_steer_pkg.sv
package fu_steer_pkg;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_OFF  = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic go;
        logic wake;
    } unit_cmd_t;

    typedef struct packed {
        logic busy;
        logic avail;
        logic sleepy;
    } unit_stat_t;

    function automatic logic [3:0] wake_cycles(input logic [2:0] code);
        return {1'b0, code} + 4'd1;
    endfunction

endpackage

// File: rtl/fu_class_table.sv
module fu_class_table #(
    parameter int OPC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OPC_W-1:0] wr_addr,
    input  logic             wr_bit,
    input  logic [OPC_W-1:0] rd_addr,
    output logic             rd_bit
);
    localparam int DEPTH = 1 << OPC_W;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_addr] <= wr_bit;
        end
    end

    assign rd_bit = bits_q[rd_addr];

endmodule

// File: rtl/fu_rr_pick.sv
module fu_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig,
    input  logic         advance,
    output logic         found,
    output logic [N-1:0] pick_oh
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = ptr_q;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (elig[j]) begin
                found = 1'b1;
                pick  = IDX_W'(j);
            end
        end
    end

    assign pick_oh = found ? (N'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance && found) begin
            ptr_q <= (pick == IDX_W'(N - 1)) ? '0 : pick + 1'b1;
        end
    end

    // R4: the pointer only moves when a free unit was actually chosen
    a_r4_advance_found: assert property (@(posedge clk) disable iff (rst)
        advance |-> found);

    // R4: the choice is always one of the eligible units
    a_r4_pick_eligible: assert property (@(posedge clk) disable iff (rst)
        found |-> ((pick_oh & ~elig) == '0));

endmodule

// File: rtl/fu_unit.sv
module fu_unit
    import fu_steer_pkg::*;
#(
    parameter int OPC_W   = 6,
    parameter int OPR_W   = 8,
    parameter int LAT     = 3,
    parameter int CNT_W   = 16,
    parameter bit IS_CRIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_mode,
    input  logic             vec_mode,
    input  logic [2:0]       wake_cfg,
    input  logic [OPR_W-1:0] idle_vec,
    input  unit_cmd_t        cmd,
    input  logic [OPC_W-1:0] opc_in,
    input  logic [OPR_W-1:0] opa_in,
    input  logic [OPR_W-1:0] opb_in,
    output unit_stat_t       stat,
    output logic             gate,
    output logic [OPC_W-1:0] opc_out,
    output logic [OPR_W-1:0] opa_out,
    output logic [OPR_W-1:0] opb_out,
    output logic [CNT_W-1:0] idle_cnt
);
    localparam int BW = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BW-1:0]    busy_cnt;
    logic             busy;
    logic [OPC_W-1:0] opc_q;
    logic [OPR_W-1:0] opa_q;
    logic [OPR_W-1:0] opb_q;
    pwr_state_e       state;
    logic [3:0]       wcnt;
    logic             hold;

    // Fixed-latency busy stub
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (cmd.go) begin
            busy_cnt <= BW'(LAT);
        end else if (busy) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign busy = (busy_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else if (cmd.go) begin
            opc_q <= opc_in;
            opa_q <= opa_in;
            opb_q <= opb_in;
        end
    end

    // Power state: only reserved units are ever gated
    generate
        if (IS_CRIT) begin : g_pwr
            always_ff @(posedge clk) begin
                if (rst) begin
                    state <= PWR_ON;
                    wcnt  <= '0;
                end else if (base_mode || vec_mode) begin
                    state <= PWR_ON;
                    wcnt  <= '0;
                end else begin
                    case (state)
                        PWR_ON: begin
                            if (!busy && !cmd.go) state <= PWR_OFF;
                        end
                        PWR_OFF: begin
                            if (cmd.wake) begin
                                state <= PWR_WAKE;
                                wcnt  <= 4'd1;
                            end
                        end
                        PWR_WAKE: begin
                            if (wcnt == wake_cycles(wake_cfg)) begin
                                state <= PWR_ON;
                                wcnt  <= '0;
                            end else begin
                                wcnt <= wcnt + 4'd1;
                            end
                        end
                        default: state <= PWR_ON;
                    endcase
                end
            end
        end else begin : g_nopwr
            assign state = PWR_ON;
            assign wcnt  = '0;
        end
    endgenerate

    assign hold = IS_CRIT && !base_mode && vec_mode && !busy && !cmd.go;
    assign gate = (state == PWR_OFF);

    assign opc_out = cmd.go ? opc_in : opc_q;
    assign opa_out = cmd.go ? opa_in : (hold ? idle_vec : opa_q);
    assign opb_out = cmd.go ? opb_in : (hold ? idle_vec : opb_q);

    assign stat.busy   = busy;
    assign stat.avail  = (state == PWR_ON) && !busy;
    assign stat.sleepy = (state == PWR_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if ((gate || hold) && idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R5: work is only handed to a powered, free unit
    a_r5_go_when_free: assert property (@(posedge clk) disable iff (rst)
        cmd.go |-> (state == PWR_ON && busy_cnt == '0));

    // R6: a gated unit holds no instruction
    a_r6_gate_idle: assert property (@(posedge clk) disable iff (rst)
        gate |-> !busy);

    // R7: wake-up is only entered on a request seen while switched off
    a_r7_wake_entry: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_WAKE && $past(state) != PWR_WAKE) |-> ($past(cmd.wake) && $past(state) == PWR_OFF));

    // R8: vector idle form never leaves a unit switched off
    a_r8_vec_no_gate: assert property (@(posedge clk) disable iff (rst)
        (vec_mode && $past(vec_mode)) |-> (state == PWR_ON));

    // R10: the idle count never goes backwards
    a_r10_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (idle_cnt >= $past(idle_cnt)));

endmodule

// File: rtl/fu_steer.sv
module fu_steer
    import fu_steer_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int OPR_W  = 8,
    parameter int N_CRIT = 1,
    parameter int N_NORM = 3,
    parameter int LAT    = 3,
    parameter int CNT_W  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_base,
    input  logic                                 cfg_idle_mode,
    input  logic [2:0]                           cfg_wake,
    input  logic [OPR_W-1:0]                     cfg_idle_vec,
    input  logic                                 tbl_we,
    input  logic [OPC_W-1:0]                     tbl_addr,
    input  logic                                 tbl_bit,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [OPC_W-1:0]                     in_opc,
    input  logic [OPR_W-1:0]                     in_opa,
    input  logic [OPR_W-1:0]                     in_opb,
    output logic [N_CRIT+N_NORM-1:0]             fu_issue,
    output logic [N_CRIT+N_NORM-1:0]             fu_busy,
    output logic [N_CRIT+N_NORM-1:0]             fu_gate,
    output logic [(N_CRIT+N_NORM)*OPC_W-1:0]     fu_opc,
    output logic [(N_CRIT+N_NORM)*OPR_W-1:0]     fu_opa,
    output logic [(N_CRIT+N_NORM)*OPR_W-1:0]     fu_opb,
    output logic [(N_CRIT+N_NORM)*CNT_W-1:0]     idle_cnt
);
    localparam int N     = N_CRIT + N_NORM;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [N-1:0] CRIT_MASK = N'((1 << N_CRIT) - 1);

    logic         cls_bit;
    logic         is_crit;
    logic [N-1:0] avail_vec;
    logic [N-1:0] sleepy_vec;
    logic [N-1:0] rr_elig;
    logic         rr_found;
    logic [N-1:0] rr_oh;
    logic         rr_adv;
    logic         crit_found;
    logic [N-1:0] crit_oh;
    logic         sleep_found;
    logic [N-1:0] sleep_oh;
    logic         accept;
    logic [N-1:0] wake_vec;
    unit_cmd_t    cmd  [N];
    unit_stat_t   stat [N];

    fu_class_table #(.OPC_W(OPC_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_bit  (tbl_bit),
        .rd_addr (in_opc),
        .rd_bit  (cls_bit)
    );

    assign is_crit = !cfg_base && cls_bit;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            avail_vec[i]  = stat[i].avail;
            sleepy_vec[i] = stat[i].sleepy;
            fu_busy[i]    = stat[i].busy;
        end
    end

    // Class-blind spreading in baseline, otherwise only the shared pool
    assign rr_elig = cfg_base ? avail_vec : (avail_vec & ~CRIT_MASK);

    fu_rr_pick #(.N(N), .IDX_W(IDX_W)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .elig    (rr_elig),
        .advance (rr_adv),
        .found   (rr_found),
        .pick_oh (rr_oh)
    );

    // Reserved pool: lowest powered free unit, else lowest switched-off one
    always_comb begin
        crit_found  = 1'b0;
        crit_oh     = '0;
        sleep_found = 1'b0;
        sleep_oh    = '0;
        for (int i = N_CRIT - 1; i >= 0; i--) begin
            if (avail_vec[i]) begin
                crit_found = 1'b1;
                crit_oh    = N'(1) << i;
            end
            if (sleepy_vec[i]) begin
                sleep_found = 1'b1;
                sleep_oh    = N'(1) << i;
            end
        end
    end

    assign in_ready = is_crit ? crit_found : rr_found;
    assign accept   = in_valid && in_ready;
    assign fu_issue = accept ? (is_crit ? crit_oh : rr_oh) : '0;
    assign rr_adv   = accept && !is_crit;
    assign wake_vec = (in_valid && is_crit && !crit_found && sleep_found) ? sleep_oh : '0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_unit
            assign cmd[g].go   = fu_issue[g];
            assign cmd[g].wake = wake_vec[g];

            fu_unit #(
                .OPC_W   (OPC_W),
                .OPR_W   (OPR_W),
                .LAT     (LAT),
                .CNT_W   (CNT_W),
                .IS_CRIT (g < N_CRIT)
            ) u_unit (
                .clk       (clk),
                .rst       (rst),
                .base_mode (cfg_base),
                .vec_mode  (cfg_idle_mode),
                .wake_cfg  (cfg_wake),
                .idle_vec  (cfg_idle_vec),
                .cmd       (cmd[g]),
                .opc_in    (in_opc),
                .opa_in    (in_opa),
                .opb_in    (in_opb),
                .stat      (stat[g]),
                .gate      (fu_gate[g]),
                .opc_out   (fu_opc[g*OPC_W +: OPC_W]),
                .opa_out   (fu_opa[g*OPR_W +: OPR_W]),
                .opb_out   (fu_opb[g*OPR_W +: OPR_W]),
                .idle_cnt  (idle_cnt[g*CNT_W +: CNT_W])
            );
        end
    endgenerate

    // R3: never more than one unit issued per cycle
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fu_issue));

    // R3: an accepted instruction lands on exactly one unit
    a_r3_accept_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ($countones(fu_issue) == 1));

    // R2: critical instructions stay inside the reserved pool
    a_r2_crit_pool: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cfg_base && cls_bit) |-> ((fu_issue & ~CRIT_MASK) == '0));

    // R2: non-critical instructions stay out of the reserved pool
    a_r2_norm_pool: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cfg_base && !cls_bit) |-> ((fu_issue & CRIT_MASK) == '0));

    // R9: baseline mode keeps every unit powered
    a_r9_base_no_gate: assert property (@(posedge clk) disable iff (rst)
        (cfg_base && $past(cfg_base)) |-> (fu_gate == '0));

    // R5: a busy unit is never issued again
    a_r5_no_issue_busy: assert property (@(posedge clk) disable iff (rst)
        (fu_issue & fu_busy) == '0);

endmodule

// File: tb/fu_steer_bench.sv
module fu_steer_bench;
    localparam int N  = 4;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_base;
    logic            cfg_idle_mode;
    logic [2:0]      cfg_wake;
    logic [7:0]      cfg_idle_vec;
    logic            tbl_we;
    logic [5:0]      tbl_addr;
    logic            tbl_bit;
    logic            in_valid;
    logic            in_ready;
    logic [5:0]      in_opc;
    logic [7:0]      in_opa;
    logic [7:0]      in_opb;
    logic [N-1:0]    fu_issue;
    logic [N-1:0]    fu_busy;
    logic [N-1:0]    fu_gate;
    logic [N*6-1:0]  fu_opc;
    logic [N*8-1:0]  fu_opa;
    logic [N*8-1:0]  fu_opb;
    logic [N*CW-1:0] idle_cnt;

    int checks = 0;
    int errors = 0;
    int got_unit;
    int got_stall;
    int issue_opa;
    int rr_exp;
    int snap0;
    int snap1;

    always #4 clk = ~clk;

    fu_steer u_fu_steer (
        .clk           (clk),
        .rst           (rst),
        .cfg_base      (cfg_base),
        .cfg_idle_mode (cfg_idle_mode),
        .cfg_wake      (cfg_wake),
        .cfg_idle_vec  (cfg_idle_vec),
        .tbl_we        (tbl_we),
        .tbl_addr      (tbl_addr),
        .tbl_bit       (tbl_bit),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_opc        (in_opc),
        .in_opa        (in_opa),
        .in_opb        (in_opb),
        .fu_issue      (fu_issue),
        .fu_busy       (fu_busy),
        .fu_gate       (fu_gate),
        .fu_opc        (fu_opc),
        .fu_opa        (fu_opa),
        .fu_opb        (fu_opb),
        .idle_cnt      (idle_cnt)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int oh_index(input logic [N-1:0] v);
        int idx = -1;
        for (int i = 0; i < N; i++) begin
            if (v[i]) idx = (idx == -1) ? i : -2;
        end
        return idx;
    endfunction

    function automatic int cnt_of(input int u);
        return int'(idle_cnt[u*CW +: CW]);
    endfunction

    task automatic send(input logic [5:0] opc, input logic [7:0] a, input logic [7:0] b);
        bit done = 1'b0;
        got_unit  = -1;
        got_stall = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_opc   = opc;
        in_opa   = a;
        in_opb   = b;
        while (!done && got_stall < 50) begin
            #1;
            if (in_ready) begin
                got_unit = oh_index(fu_issue);
                if (got_unit >= 0) issue_opa = int'(fu_opa[got_unit*8 +: 8]);
                done = 1'b1;
            end else begin
                got_stall++;
                @(negedge clk);
            end
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic tbl_write(input logic [5:0] addr, input logic b);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = addr; tbl_bit = b;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    function automatic bit crit_of(input int opc);
        return (opc % 3) == 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_base = 1'b0; cfg_idle_mode = 1'b1; cfg_wake = 3'd0;
        cfg_idle_vec = 8'hA5; tbl_we = 1'b0; tbl_addr = '0; tbl_bit = 1'b0;
        in_valid = 1'b0; in_opc = '0; in_opa = '0; in_opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy in reset", fu_busy, 0);
        chk("R11", "gate in reset", fu_gate, 0);
        chk("R11", "issue in reset", fu_issue, 0);
        chk("R11", "idle counters in reset", idle_cnt == '0, 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "no gating in vector form", fu_gate, 0);

        // R1: table starts all non-critical, so opcode 0 goes to the shared pool
        send(6'd0, 8'h01, 8'h02);
        chk("R1", "reset class of opcode 0", got_unit, 1);
        rr_exp = 2;
        repeat (4) @(posedge clk);
        for (int o = 0; o < 64; o++) tbl_write(6'(o), crit_of(o));

        // R1 R2 R4: full opcode sweep with all units free before each send
        for (int o = 0; o < 64; o++) begin
            send(6'(o), 8'(o), 8'(o + 1));
            if (crit_of(o)) begin
                chk("R2", "critical opcode routed to reserved unit", got_unit, 0);
            end else begin
                chk("R4", "non-critical round-robin", got_unit, rr_exp);
                rr_exp = (rr_exp == 3) ? 1 : rr_exp + 1;
            end
            repeat (4) @(posedge clk);
        end

        // R1: a rewrite flips the class from the next cycle
        tbl_write(6'd0, 1'b0);
        send(6'd0, 8'h00, 8'h00);
        chk("R1", "rewritten opcode now non-critical", got_unit, rr_exp);
        rr_exp = (rr_exp == 3) ? 1 : rr_exp + 1;
        repeat (4) @(posedge clk);
        tbl_write(6'd0, 1'b1);

        // R4 R5: back-to-back non-critical traffic fills the pool then stalls
        for (int k = 0; k < 3; k++) begin
            send(6'd2, 8'h40, 8'h41);
            chk("R4", "back-to-back unit", got_unit, rr_exp);
            chk("R5", "no stall with free unit", got_stall, 0);
            rr_exp = (rr_exp == 3) ? 1 : rr_exp + 1;
        end
        send(6'd2, 8'h42, 8'h43);
        chk("R5", "stall while pool busy", got_stall, 1);
        chk("R4", "first freed unit reused", got_unit, rr_exp);
        repeat (5) @(posedge clk);

        // R8: operands held at the idle vector, carried through on issue
        @(negedge clk); #1;
        chk("R8", "idle opa is idle vector", fu_opa[7:0], 8'hA5);
        chk("R8", "idle opb is idle vector", fu_opb[7:0], 8'hA5);
        send(6'd0, 8'h11, 8'h22);
        chk("R8", "issue-cycle operand", issue_opa, 8'h11);
        @(negedge clk); #1;
        chk("R8", "latched operand while busy", fu_opa[7:0], 8'h11);
        chk("R5", "busy after issue", fu_busy[0], 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R5", "free after LAT cycles", fu_busy[0], 0);
        chk("R8", "back to idle vector", fu_opa[7:0], 8'hA5);

        // R10: vector-held cycles counted for the reserved unit only
        snap0 = cnt_of(0); snap1 = cnt_of(1);
        repeat (10) @(negedge clk);
        #1;
        chk("R10", "vector-hold count delta", cnt_of(0) - snap0, 10);
        chk("R10", "shared unit not counted", cnt_of(1) - snap1, 0);

        // R6: switch to power-gate form
        @(negedge clk);
        cfg_idle_mode = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R6", "reserved unit gated", fu_gate[0], 1);
        chk("R6", "shared units not gated", fu_gate[3:1], 0);
        snap0 = cnt_of(0);
        repeat (5) @(negedge clk);
        #1;
        chk("R10", "gated count delta", cnt_of(0) - snap0, 5);
        send(6'd2, 8'h01, 8'h01);
        chk("R6", "shared pool has no wake stall", got_stall, 0);
        rr_exp = (rr_exp == 3) ? 1 : rr_exp + 1;

        // R7: wake stall for every latency setting
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            cfg_wake = 3'(w);
            repeat (6) @(posedge clk);
            send(6'd3, 8'(w), 8'(w));
            chk("R7", "wake stall length", got_stall, w + 2);
            chk("R7", "woken unit issued", got_unit, 0);
        end
        repeat (6) @(negedge clk);
        #1;
        chk("R6", "unit gated again after work", fu_gate[0], 1);

        // R9: baseline through a reset so the spreading start is known
        @(negedge clk);
        rst = 1'b1; cfg_base = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            send((k % 2 == 1) ? 6'd0 : 6'd2, 8'(8'h30 + k), 8'h00);
            chk("R9", "class-blind round-robin", got_unit, k % 4);
            repeat (4) @(posedge clk);
            chk("R9", "no gating in baseline", fu_gate, 0);
        end
        @(negedge clk);
        cfg_idle_mode = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk("R9", "operands not forced in baseline", fu_opa[7:0], 8'h34);
        chk("R9", "no idle counting in baseline", cnt_of(0), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule